// File: doc/BRIEF.md
# Watchdog Timer with Two-Key Feed Unlock

This block is a watchdog peripheral on a simple single-cycle register bus. Software sets a reload value and turns the watchdog on through a mode register. The watchdog stays idle until software completes its first feed. After that a down counter steps once per tick pulse. If software does not feed again before the counter runs out, the block raises a sticky timeout flag and, when asked to, sends a one-clock reset request to the system reset logic.

A feed is a two-write handshake on the feed register. The first key (0xAA) arms the sequence. The very next access that lands anywhere in the watchdog's four-word window must be the second key (0x55) written to the same register. Any other access in that window, read or write, trips the watchdog at once, just like a timeout. Bus traffic to other addresses does not touch the armed state. So an interrupt handler that leaves the watchdog alone does no harm between the two writes.

Top module: `wdt_unlock`

## Requirements
- R1: Writing KEY_FIRST (0xAA, low 8 data bits) to the feed register and then KEY_SECOND (0x55) to the feed register, with no watchdog access between them, is a valid feed. While the watchdog is enabled, a valid feed loads the count from the reload register on the clock edge of the second write.
- R2: While a feed is armed, the next access inside the watchdog window ends the sequence. Any access other than a KEY_SECOND write to the feed register is a violation. This covers a read of any register, a write to another register, and a feed write with any other data. When the watchdog is enabled, a violation sets the timeout flag on that edge.
- R3: A bus access whose word address has any bit set above bit 1 lies outside the window. Such an access has no effect, is never a violation, and leaves an armed sequence armed.
- R4: The reload register holds CNT_W = 32 bits and resets to 0xFFFFFFFF. A feed with 0xFFFFFFFF loads the count with 0xFFFFFFFF.
- R5: After reset the counter does not run. It starts only on a valid feed made while the enable bit is set. Feeds made while the enable bit is clear change nothing. Ticks before the first accepted feed leave the count at its reset value of 0.
- R6: While running, the count drops by one on each cycle with tick high. Ticks while stopped do nothing.
- R7: A tick while running with a count of 1 or 0 leaves the count at 0, sets the timeout flag and stops the counter. Later ticks leave the count at 0 until the next accepted feed.
- R8: A timeout or an enabled violation drives rst_req high for exactly one clock in the next cycle when the reset-enable bit is set. When reset-enable is clear, only the flag is set.
- R9: Mode write bit 0 sets the enable bit, and writing 0 to it has no effect. Bit 1 sets or clears reset-enable. Both can be set in one write. The timeout flag stays set until reset.
- R10: The register map uses the word address bus_addr[1:0]. Address 0 is mode: bit0 enable, bit1 reset-enable, bit2 timeout flag (read only). Address 1 is reload. Address 2 is feed, which reads as 0. Address 3 is the current count, which is read only and ignores writes. A read outside the window returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational for the current access |
| tick | input | 1 | Count enable pulse |
| rst_req | output | 1 | One-clock reset request |
| tmo_flag | output | 1 | Sticky timeout flag |

## Verification
The bench uses the default widths: a 32-bit counter, an 8-bit address and 8-bit keys. The full 0xFFFFFFFF reload is therefore checked directly, while short timeouts come from small values written to the reload register. The 8-bit address lets the bench reach the outside-window case with an address that has a high bit set. The full key width lets it send a wrong second key.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  typedef enum logic [1:0] {
    REG_MODE  = 2'd0,
    REG_LOAD  = 2'd1,
    REG_FEED  = 2'd2,
    REG_COUNT = 2'd3
  } wdt_reg_e;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_ARMED = 1'b1
  } seq_st_e;

  localparam int MODE_EN_BIT   = 0;
  localparam int MODE_RSTE_BIT = 1;
  localparam int MODE_FLAG_BIT = 2;
endpackage

// File: rtl/wdt_decode.sv
`timescale 1ns/1ps
module wdt_decode
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              in_window,
  output wdt_reg_e          reg_sel
);
  localparam int HI_W = ADDR_W - 2;

  assign in_window = bus_valid && (bus_addr[ADDR_W-1:2] == HI_W'(0));
  assign reg_sel   = wdt_reg_e'(bus_addr[1:0]);
endmodule

// File: rtl/wdt_feed_seq.sv
`timescale 1ns/1ps
module wdt_feed_seq
  import wdt_pkg::*;
#(
  parameter int               KEY_W      = 8,
  parameter logic [KEY_W-1:0] KEY_FIRST  = 8'hAA,
  parameter logic [KEY_W-1:0] KEY_SECOND = 8'h55
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_window,
  input  logic             is_write,
  input  wdt_reg_e         reg_sel,
  input  logic [KEY_W-1:0] key,
  output logic             feed_ok,
  output logic             seq_viol
);
  seq_st_e st_q, st_d;
  logic    feed_wr;

  assign feed_wr = in_window && is_write && (reg_sel == REG_FEED);

  always_comb begin
    st_d     = st_q;
    feed_ok  = 1'b0;
    seq_viol = 1'b0;
    case (st_q)
      SEQ_IDLE: begin
        if (feed_wr && key == KEY_FIRST) st_d = SEQ_ARMED;
      end
      SEQ_ARMED: begin
        if (in_window) begin
          st_d = SEQ_IDLE;
          if (feed_wr && key == KEY_SECOND) feed_ok  = 1'b1;
          else                              seq_viol = 1'b1;
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= SEQ_IDLE;
    else        st_q <= st_d;
  end

  AST_OK_NOT_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
    feed_ok |-> !seq_viol);  // R2
  AST_VIOL_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    seq_viol |-> in_window);  // R3
  AST_ARMED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_ARMED && !in_window) |=> (st_q == SEQ_ARMED));  // R3
endmodule

// File: rtl/wdt_down_counter.sv
`timescale 1ns/1ps
module wdt_down_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             fire
);
  logic running_q;

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] c);
    return (c == '0) ? '0 : c - CNT_W'(1);
  endfunction

  function automatic logic at_end(input logic [CNT_W-1:0] c);
    return c <= CNT_W'(1);
  endfunction

  assign fire = running_q && tick && !load && at_end(count);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count     <= '0;
      running_q <= 1'b0;
    end else if (load) begin
      count     <= load_val;
      running_q <= 1'b1;
    end else if (running_q && tick) begin
      count <= step_down(count);
      if (at_end(count)) running_q <= 1'b0;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && tick && !load && count > CNT_W'(1)) |=> (count == $past(count) - CNT_W'(1)));  // R6
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_q && !load) |=> $stable(count));  // R6
  AST_FIRE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (count == '0 && !running_q));  // R7
endmodule

// File: rtl/wdt_unlock.sv
`timescale 1ns/1ps
module wdt_unlock
  import wdt_pkg::*;
#(
  parameter int               ADDR_W     = 8,
  parameter int               DATA_W     = 32,
  parameter int               CNT_W      = 32,
  parameter int               KEY_W      = 8,
  parameter logic [KEY_W-1:0] KEY_FIRST  = 8'hAA,
  parameter logic [KEY_W-1:0] KEY_SECOND = 8'h55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick,
  output logic              rst_req,
  output logic              tmo_flag
);
  logic             in_window, feed_ok, seq_viol, fire, trip, load;
  wdt_reg_e         reg_sel;
  logic [CNT_W-1:0] count, reload_q;
  logic             en_q, rste_q, flag_q;
  logic             mode_wr, reload_wr;

  wdt_decode #(.ADDR_W(ADDR_W)) u_decode (
    .bus_valid (bus_valid),
    .bus_addr  (bus_addr),
    .in_window (in_window),
    .reg_sel   (reg_sel)
  );

  wdt_feed_seq #(.KEY_W(KEY_W), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_window (in_window),
    .is_write  (bus_write),
    .reg_sel   (reg_sel),
    .key       (bus_wdata[KEY_W-1:0]),
    .feed_ok   (feed_ok),
    .seq_viol  (seq_viol)
  );

  assign load = feed_ok && en_q;

  wdt_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (reload_q),
    .tick     (tick),
    .count    (count),
    .fire     (fire)
  );

  assign mode_wr   = in_window && bus_write && (reg_sel == REG_MODE);
  assign reload_wr = in_window && bus_write && (reg_sel == REG_LOAD);
  assign trip      = fire || (seq_viol && en_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      rste_q   <= 1'b0;
      flag_q   <= 1'b0;
      reload_q <= '1;
      rst_req  <= 1'b0;
    end else begin
      if (mode_wr) begin
        en_q   <= en_q | bus_wdata[MODE_EN_BIT];
        rste_q <= bus_wdata[MODE_RSTE_BIT];
      end
      if (reload_wr) reload_q <= bus_wdata[CNT_W-1:0];
      flag_q  <= flag_q | trip;
      rst_req <= trip && rste_q;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (in_window) begin
      case (reg_sel)
        REG_MODE: begin
          bus_rdata[MODE_EN_BIT]   = en_q;
          bus_rdata[MODE_RSTE_BIT] = rste_q;
          bus_rdata[MODE_FLAG_BIT] = flag_q;
        end
        REG_LOAD:  bus_rdata[CNT_W-1:0] = reload_q;
        REG_COUNT: bus_rdata[CNT_W-1:0] = count;
        default:   bus_rdata = '0;
      endcase
    end
  end

  assign tmo_flag = flag_q;

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);  // R8
  AST_REQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> flag_q);  // R8
  AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q);  // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |=> flag_q);  // R9
  AST_LOAD_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (feed_ok && !en_q) |=> $stable(count));  // R5
endmodule

// File: tb/wdt_unlock_bench.sv
`timescale 1ns/1ps
module wdt_unlock_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0, tick = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rst_req, tmo_flag;

  int vectors = 0, miscompares = 0;
  int pulses = 0, wide = 0;
  logic prev_req = 1'b0;
  logic mon_req = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  localparam logic [7:0] A_MODE = 8'd0, A_LOAD = 8'd1, A_FEED = 8'd2, A_CNT = 8'd3, A_OUT = 8'h40;

  wdt_unlock u_wdt_unlock (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick(tick), .rst_req(rst_req), .tmo_flag(tmo_flag)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] model_count(input logic [31:0] start, input int n);
    return (start > 32'(n)) ? start - 32'(n) : 32'd0;
  endfunction

  always @(negedge clk) begin
    if (rst_req) pulses++;
    if (rst_req && prev_req) wide++;
    prev_req = rst_req;
  end

  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (mon_req) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        vectors++;
        if (bus_rdata !== e) begin
          miscompares++;
          $display("FAIL %s: read %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic chk(input int act, input int exp, input string t);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t); mon_req = 1'b1;
    @(negedge clk);
    mon_req = 1'b0; bus_valid = 1'b0;
  endtask

  task automatic rd_only(input logic [7:0] a);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic feed();
    wr(A_FEED, 32'hAA);
    wr(A_FEED, 32'h55);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    vectors++; miscompares++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    do_reset();
    // reset state and register map
    rd(A_MODE, 32'd0, "R10 mode reset");
    rd(A_LOAD, 32'hFFFF_FFFF, "R4 reload reset");
    rd(A_CNT, 32'd0, "R10 count reset");
    rd(A_FEED, 32'd0, "R10 feed reads zero");
    rd(A_OUT, 32'd0, "R3 outside read zero");
    chk(pulses, 0, "R8 no pulse at reset");
    // enable plus reset-enable in one write; no run before feed
    wr(A_MODE, 32'd3);
    rd(A_MODE, 32'd3, "R9 both bits one write");
    wr(A_LOAD, 32'd5);
    ticks(20);
    rd(A_CNT, 32'd0, "R5 idle before first feed");
    rd(A_MODE, 32'd3, "R5 no timeout before feed");
    feed();
    rd(A_CNT, 32'd5, "R1 feed loads reload");
    ticks(3);
    rd(A_CNT, model_count(32'd5, 3), "R6 decrement per tick");
    wr(A_CNT, 32'h99);
    rd(A_CNT, model_count(32'd5, 3), "R10 count ignores writes");
    ticks(2);
    rd(A_MODE, 32'd7, "R7 flag on expiry");
    chk(pulses, 1, "R8 pulse on timeout");
    chk(wide, 0, "R8 pulse one clock");
    chk(int'(tmo_flag), 1, "R7 flag output");
    ticks(5);
    rd(A_CNT, 32'd0, "R7 stopped at zero");
    chk(pulses, 1, "R7 single expiry");
    wr(A_MODE, 32'd0);
    rd(A_MODE, 32'd5, "R9 enable sticky, flag sticky");

    // outside accesses keep sequence armed; violation by read
    do_reset();
    wr(A_LOAD, 32'd10);
    wr(A_MODE, 32'd3);
    feed();
    ticks(4);
    rd(A_CNT, model_count(32'd10, 4), "R6 second run");
    wr(A_FEED, 32'hAA);
    wr(A_OUT, 32'h0);
    rd_only(A_OUT + 8'd1);
    wr(A_FEED, 32'h55);
    rd(A_CNT, 32'd10, "R3 outside traffic ignored by sequence");
    rd(A_MODE, 32'd3, "R3 no trip");
    chk(pulses, 1, "R3 no pulse");
    wr(A_FEED, 32'hAA);
    rd_only(A_CNT);
    rd(A_MODE, 32'd7, "R2 read while armed trips");
    chk(pulses, 2, "R2 pulse on violation");

    // violation with reset-enable clear
    do_reset();
    wr(A_MODE, 32'd1);
    wr(A_LOAD, 32'd7);
    feed();
    wr(A_FEED, 32'hAA);
    wr(A_LOAD, 32'd9);
    rd(A_MODE, 32'd5, "R8 flag only without reset-enable");
    chk(pulses, 2, "R8 no pulse without reset-enable");

    // wrong second key
    do_reset();
    wr(A_MODE, 32'd3);
    feed();
    wr(A_FEED, 32'hAA);
    wr(A_FEED, 32'h12);
    rd(A_MODE, 32'd7, "R2 wrong second key trips");
    chk(pulses, 3, "R2 pulse on wrong key");

    // longest reload
    do_reset();
    wr(A_MODE, 32'd3);
    feed();
    rd(A_CNT, 32'hFFFF_FFFF, "R4 full reload accepted");
    ticks(50);
    rd(A_CNT, model_count(32'hFFFF_FFFF, 50), "R4 full reload counts");
    rd(A_MODE, 32'd3, "R4 no early timeout");

    // feed while disabled ignored
    do_reset();
    wr(A_LOAD, 32'd3);
    feed();
    ticks(10);
    rd(A_CNT, 32'd0, "R5 feed while disabled ignored");
    wr(A_MODE, 32'd1);
    ticks(5);
    rd(A_CNT, 32'd0, "R5 enable alone does not start");
    rd(A_MODE, 32'd1, "R5 no timeout after enable only");
    chk(pulses, 3, "R8 total pulses");

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule